// File: doc/BRIEF.md
# Layer-Aware Program Start-Step Sequencer

This block sequences incremental step-pulse programming for a vertical flash array that stores three bits per cell. Each word-line layer carries four strings, numbered 0 to 3. Lower, middle and upper page data of a cell are written together in one full-sequence operation. Strings are programmed in a fixed order: all four strings of word line 0, then all four strings of word line 1, and so on. Every loop is one program pulse followed by one verify phase. The pulse step index rises by one per loop.

Cells on the same word-line layer program at almost the same speed. The sequencer therefore learns a start step while string 0 of a layer is programmed and keeps it in a small per-layer table. String 0 always starts from the default step. Strings 1 to 3 of that layer start from the learned value and skip the early loops that could not pass. A block-erase signal clears the table. A programmable loop limit ends an operation that never reaches all-pass.

The array model supplies the verify results. For each verify phase it returns a valid strobe, an all-pass flag and a count of passing bits. Pump generation and sensing are outside this block.

Top module: `pgm_start_seq`

## Requirements
- R1: After reset, pulse_o, verify_o, busy_o, done_o and fail_o are all low and step_o is 0; at most one of pulse_o, verify_o, done_o and fail_o is high in any cycle.
- R2: Each loop is one cycle of pulse_o followed by verify_o, which stays high until vfy_valid_i; each new loop in an operation drives step_o one higher than the loop before.
- R3: An operation on string 0, or on any string of a layer with no learned entry, starts at step 0.
- R4: During string 0, the first verify with a nonzero pass_cnt_i at step k stores max(k - margin_i, 0) as the layer's entry; later verifies in that operation do not change it.
- R5: An operation on strings 1, 2 or 3 of a layer with a learned entry starts at that entry.
- R6: Operations on strings 1 to 3, and string-0 operations that never see a pass, leave the layer's entry unchanged.
- R7: A verify with vfy_done_i high ends the operation: done_o rises on the next cycle and stays high until the next accepted start_i, with no further pulses.
- R8: When the loop count reaches max_loops_i (a value of 0 acts as 1) without all-pass, fail_o rises, stays high until the next accepted start_i, and no further pulse is issued.
- R9: An erase_i pulse clears every learned entry, so the next string 1 to 3 operation starts at step 0.
- R10: start_i is ignored while busy_o is high; the running operation and page_o are unaffected.
- R11: page_o is the lower-page number of the operation, 12 x word line + 3 x string, held from the accepted start until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| erase_i | input | 1 | Block erase: clears all learned start steps |
| start_i | input | 1 | Start a program operation (accepted when idle) |
| wl_i | input | WL_W | Target word-line layer |
| str_i | input | 2 | Target string within the layer |
| margin_i | input | STEP_W | Amount subtracted from the first-pass step when learning |
| max_loops_i | input | LOOP_W | Loop limit before failure |
| vfy_valid_i | input | 1 | Verify result valid |
| vfy_done_i | input | 1 | All bits passed verify |
| pass_cnt_i | input | CNT_W | Number of bits passing verify |
| step_o | output | STEP_W | Current program pulse step index |
| page_o | output | PAGE_W | Lower-page number of the operation |
| pulse_o | output | 1 | Program pulse strobe |
| verify_o | output | 1 | Verify phase strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation completed with all bits passing |
| fail_o | output | 1 | Operation hit the loop limit |

## Verification
A corrupted learned entry is invisible until the next string 1 to 3 operation on that layer. Its start step then appears on step_o in the first pulse cycle, one cycle after start_i. The bench therefore pairs each string-0 operation with later strings on the same layer, and also checks layers that have never been learned and layers cleared by erase. An off-by-one loop counter or step increment moves the cycle in which done_o or fail_o rises and changes the number of pulses, so the scoreboard compares the pulse count and the first step of every operation. A start that leaks through while busy would change page_o or restart the pulse count within a cycle.

// File: rtl/pss_pkg.sv
package pss_pkg;

    // Operation phases of the program sequencer
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_PULSE  = 3'd1,
        S_VERIFY = 3'd2,
        S_DONE   = 3'd3,
        S_FAIL   = 3'd4
    } seq_st_e;

    // Number of strings sharing one word-line layer
    localparam int STRINGS_PER_LAYER = 4;
    // Pages written together per string (lower, middle, upper)
    localparam int PAGES_PER_STRING  = 3;

endpackage

// File: rtl/pss_layer_tbl.sv
// Per-layer table of learned start steps with a valid flag per entry.
module pss_layer_tbl #(
    parameter int WL_N   = 8,
    parameter int STEP_W = 5,
    parameter int WL_W   = $clog2(WL_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [WL_W-1:0]   waddr_i,
    input  logic [STEP_W-1:0] wdata_i,
    input  logic [WL_W-1:0]   raddr_i,
    output logic              rhit_o,
    output logic [STEP_W-1:0] rdata_o
);

    logic [WL_N-1:0]   vld_vec;
    logic [STEP_W-1:0] val_arr [WL_N];

    for (genvar g = 0; g < WL_N; g++) begin : g_ent
        logic              v_d, v_q;
        logic [STEP_W-1:0] x_d, x_q;

        always_comb begin
            v_d = v_q;
            x_d = x_q;
            if (clr_i) begin
                v_d = 1'b0;
            end else if (we_i && (waddr_i == WL_W'(g))) begin
                v_d = 1'b1;
                x_d = wdata_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                x_q <= '0;
            end else begin
                v_q <= v_d;
                x_q <= x_d;
            end
        end

        assign vld_vec[g] = v_q;
        assign val_arr[g] = x_q;
    end

    assign rhit_o  = vld_vec[raddr_i];
    assign rdata_o = val_arr[raddr_i];

endmodule

// File: rtl/pss_step_calc.sv
// Start-step selection and learned-value computation.
module pss_step_calc #(
    parameter int STEP_W    = 5,
    parameter int INIT_STEP = 0
) (
    input  logic [1:0]        str_i,
    input  logic              hit_i,
    input  logic [STEP_W-1:0] entry_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [STEP_W-1:0] margin_i,
    output logic [STEP_W-1:0] start_o,
    output logic [STEP_W-1:0] capture_o
);

    localparam logic [STEP_W-1:0] DEF_STEP = STEP_W'(INIT_STEP);

    always_comb begin
        // String 0 always learns from the default; other strings reuse the layer value
        if ((str_i != 2'd0) && hit_i) begin
            start_o = entry_i;
        end else begin
            start_o = DEF_STEP;
        end
        // First-pass step backed off by the margin, floored at zero
        if (step_i > margin_i) begin
            capture_o = step_i - margin_i;
        end else begin
            capture_o = '0;
        end
    end

endmodule

// File: rtl/pss_loop_fsm.sv
// Pulse/verify loop control, loop limit and learning strobe.
module pss_loop_fsm
    import pss_pkg::*;
#(
    parameter int WL_W   = 3,
    parameter int STEP_W = 5,
    parameter int LOOP_W = 6,
    parameter int CNT_W  = 8,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WL_W-1:0]   wl_i,
    input  logic [1:0]        str_i,
    input  logic [STEP_W-1:0] start_step_i,
    input  logic [LOOP_W-1:0] max_loops_i,
    input  logic              vfy_valid_i,
    input  logic              vfy_done_i,
    input  logic [CNT_W-1:0]  pass_cnt_i,
    output logic [STEP_W-1:0] step_o,
    output logic [WL_W-1:0]   wl_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              pulse_o,
    output logic              verify_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              learn_we_o
);

    localparam int IDX_W = WL_W + 2;
    localparam logic [PAGE_W-1:0] PG_MUL = PAGE_W'(PAGES_PER_STRING);

    typedef struct packed {
        seq_st_e           st;
        logic [STEP_W-1:0] step;
        logic [LOOP_W-1:0] loops;
        logic [WL_W-1:0]   wl;
        logic [1:0]        str;
        logic              learned;
        logic [PAGE_W-1:0] page;
    } seq_t;

    seq_t              s_d, s_q;
    logic              we_d;
    logic [LOOP_W-1:0] loops_nx;
    logic [IDX_W-1:0]  str_idx;
    logic              idle_like;

    assign str_idx   = {wl_i, str_i};
    assign idle_like = (s_q.st == S_IDLE) || (s_q.st == S_DONE) || (s_q.st == S_FAIL);

    always_comb begin
        s_d      = s_q;
        we_d     = 1'b0;
        loops_nx = s_q.loops + 1'b1;
        if (idle_like) begin
            if (start_i) begin
                s_d.st      = S_PULSE;
                s_d.step    = start_step_i;
                s_d.loops   = '0;
                s_d.wl      = wl_i;
                s_d.str     = str_i;
                s_d.learned = 1'b0;
                s_d.page    = PAGE_W'(str_idx) * PG_MUL;
            end
        end else if (s_q.st == S_PULSE) begin
            s_d.st = S_VERIFY;
        end else if (s_q.st == S_VERIFY) begin
            if (vfy_valid_i) begin
                // Learn only from the first passing verify of string 0
                if ((s_q.str == 2'd0) && !s_q.learned && (pass_cnt_i != '0)) begin
                    we_d        = 1'b1;
                    s_d.learned = 1'b1;
                end
                s_d.loops = loops_nx;
                if (vfy_done_i) begin
                    s_d.st = S_DONE;
                end else if (loops_nx >= max_loops_i) begin
                    s_d.st = S_FAIL;
                end else begin
                    s_d.st = S_PULSE;
                    if (!(&s_q.step)) begin
                        s_d.step = s_q.step + 1'b1;
                    end
                end
            end
        end else begin
            s_d.st = S_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st      <= S_IDLE;
            s_q.step    <= '0;
            s_q.loops   <= '0;
            s_q.wl      <= '0;
            s_q.str     <= '0;
            s_q.learned <= 1'b0;
            s_q.page    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign step_o     = s_q.step;
    assign wl_o       = s_q.wl;
    assign page_o     = s_q.page;
    assign pulse_o    = (s_q.st == S_PULSE);
    assign verify_o   = (s_q.st == S_VERIFY);
    assign busy_o     = pulse_o || verify_o;
    assign done_o     = (s_q.st == S_DONE);
    assign fail_o     = (s_q.st == S_FAIL);
    assign learn_we_o = we_d;

endmodule

// File: rtl/pgm_start_seq.sv
// Layer-aware program start-step sequencer (top).
module pgm_start_seq #(
    parameter int WL_N      = 8,
    parameter int STEP_W    = 5,
    parameter int LOOP_W    = 6,
    parameter int CNT_W     = 8,
    parameter int INIT_STEP = 0,
    localparam int WL_W     = $clog2(WL_N),
    localparam int PAGE_W   = WL_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_i,
    input  logic              start_i,
    input  logic [WL_W-1:0]   wl_i,
    input  logic [1:0]        str_i,
    input  logic [STEP_W-1:0] margin_i,
    input  logic [LOOP_W-1:0] max_loops_i,
    input  logic              vfy_valid_i,
    input  logic              vfy_done_i,
    input  logic [CNT_W-1:0]  pass_cnt_i,
    output logic [STEP_W-1:0] step_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              pulse_o,
    output logic              verify_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o
);

    logic              tbl_hit;
    logic [STEP_W-1:0] tbl_val;
    logic [STEP_W-1:0] start_step;
    logic [STEP_W-1:0] cap_val;
    logic              learn_we;
    logic [WL_W-1:0]   cur_wl;

    pss_layer_tbl #(
        .WL_N   (WL_N),
        .STEP_W (STEP_W),
        .WL_W   (WL_W)
    ) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (erase_i),
        .we_i    (learn_we),
        .waddr_i (cur_wl),
        .wdata_i (cap_val),
        .raddr_i (wl_i),
        .rhit_o  (tbl_hit),
        .rdata_o (tbl_val)
    );

    pss_step_calc #(
        .STEP_W    (STEP_W),
        .INIT_STEP (INIT_STEP)
    ) u_calc (
        .str_i     (str_i),
        .hit_i     (tbl_hit),
        .entry_i   (tbl_val),
        .step_i    (step_o),
        .margin_i  (margin_i),
        .start_o   (start_step),
        .capture_o (cap_val)
    );

    pss_loop_fsm #(
        .WL_W   (WL_W),
        .STEP_W (STEP_W),
        .LOOP_W (LOOP_W),
        .CNT_W  (CNT_W),
        .PAGE_W (PAGE_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .wl_i         (wl_i),
        .str_i        (str_i),
        .start_step_i (start_step),
        .max_loops_i  (max_loops_i),
        .vfy_valid_i  (vfy_valid_i),
        .vfy_done_i   (vfy_done_i),
        .pass_cnt_i   (pass_cnt_i),
        .step_o       (step_o),
        .wl_o         (cur_wl),
        .page_o       (page_o),
        .pulse_o      (pulse_o),
        .verify_o     (verify_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .fail_o       (fail_o),
        .learn_we_o   (learn_we)
    );

endmodule

// File: rtl/pgm_start_seq_chk.sv
// Protocol checker bound to the sequencer top.
module pgm_start_seq_chk #(
    parameter int STEP_W = 5,
    parameter int PAGE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              vfy_valid_i,
    input logic              vfy_done_i,
    input logic [STEP_W-1:0] step_o,
    input logic [PAGE_W-1:0] page_o,
    input logic              pulse_o,
    input logic              verify_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              fail_o
);

    assert_one_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pulse_o, verify_o, done_o, fail_o}));

    assert_pulse_then_verify_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> verify_o);

    assert_step_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && $past(verify_o)) |->
            ((step_o == STEP_W'($past(step_o) + 1'b1)) || (&$past(step_o))));

    assert_done_on_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (verify_o && vfy_valid_i && vfy_done_i) |=> done_o);

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && !pulse_o));

    assert_fail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> (fail_o && !pulse_o));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(page_o));

endmodule

bind pgm_start_seq pgm_start_seq_chk #(
    .STEP_W (STEP_W),
    .PAGE_W (PAGE_W)
) u_chk (.*);

// File: tb/test_pgm_start_seq.sv
module test_pgm_start_seq;

    localparam int WL_N   = 8;
    localparam int STEP_W = 5;
    localparam int LOOP_W = 6;
    localparam int CNT_W  = 8;
    localparam int WL_W   = 3;
    localparam int PAGE_W = 7;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              erase_i, start_i;
    logic [WL_W-1:0]   wl_i;
    logic [1:0]        str_i;
    logic [STEP_W-1:0] margin_i;
    logic [LOOP_W-1:0] max_loops_i;
    logic              vfy_valid_i, vfy_done_i;
    logic [CNT_W-1:0]  pass_cnt_i;
    logic [STEP_W-1:0] step_o;
    logic [PAGE_W-1:0] page_o;
    logic              pulse_o, verify_o, busy_o, done_o, fail_o;

    always #4 clk = ~clk;   // 125 MHz

    pgm_start_seq i_pgm_start_seq (
        .clk(clk), .rst_n(rst_n), .erase_i(erase_i), .start_i(start_i),
        .wl_i(wl_i), .str_i(str_i), .margin_i(margin_i), .max_loops_i(max_loops_i),
        .vfy_valid_i(vfy_valid_i), .vfy_done_i(vfy_done_i), .pass_cnt_i(pass_cnt_i),
        .step_o(step_o), .page_o(page_o), .pulse_o(pulse_o), .verify_o(verify_o),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
    );

    typedef struct {
        bit    fail;
        int    first;
        int    loops;
        int    page;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   thr = 0;
    int   spr = 0;
    bit   mdl_v[WL_N];
    int   mdl_s[WL_N];

    task automatic chk(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Array model: passing bits appear at step thr, all pass at thr+spr
    always @(negedge clk) begin
        vfy_valid_i = verify_o;
        vfy_done_i  = verify_o && (int'(step_o) >= thr + spr);
        if (verify_o && (int'(step_o) >= thr))
            pass_cnt_i = CNT_W'((int'(step_o) - thr + 1) * 16);
        else
            pass_cnt_i = '0;
    end

    // Monitor: count pulses, compare each finished operation with the queue
    int pc = 0;
    int first_s = 0;
    int prev_s = 0;
    bit ended = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pulse_o) begin
                if (pc == 0) first_s = int'(step_o);
                else chk(int'(step_o) == prev_s + 1, "R2 step increment", int'(step_o), prev_s + 1);
                prev_s = int'(step_o);
                pc++;
                ended = 1'b0;
            end
            if ((done_o || fail_o) && !ended) begin
                ended = 1'b1;
                if (q.size() == 0) begin
                    chk(1'b0, "scoreboard empty", 0, 1);
                end else begin
                    cur = q.pop_front();
                    chk(fail_o == cur.fail, {cur.tag, " R7/R8 outcome fail flag"}, int'(fail_o), int'(cur.fail));
                    chk(first_s == cur.first, {cur.tag, " start step"}, first_s, cur.first);
                    chk(pc == cur.loops, {cur.tag, " R2 loop count"}, pc, cur.loops);
                    chk(int'(page_o) == cur.page, {cur.tag, " R11 page"}, int'(page_o), cur.page);
                end
                pc = 0;
            end
        end
    end

    // Driver: predict, push, launch, wait for the end, update the model table
    task automatic run_op(int wl, int str, int t, int s, int m, int mx, string tag, bit poke);
        exp_t e;
        int st, need, cap, last;
        st   = (str != 0 && mdl_v[wl]) ? mdl_s[wl] : 0;
        need = (t + s >= st) ? (t + s - st + 1) : 1;
        cap  = (mx < 1) ? 1 : mx;
        e.fail  = (need > cap);
        e.loops = e.fail ? cap : need;
        e.first = st;
        e.page  = 12 * wl + 3 * str;
        e.tag   = tag;
        last    = st + e.loops - 1;
        q.push_back(e);
        thr = t;
        spr = s;
        margin_i    = STEP_W'(m);
        max_loops_i = LOOP_W'(mx);
        wl_i        = WL_W'(wl);
        str_i       = 2'(str);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            wl_i  = WL_W'(wl ^ 3);
            str_i = 2'(str ^ 1);
            start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
        end
        while (!(done_o || fail_o)) @(negedge clk);
        @(negedge clk);
        if (str == 0 && t <= last) begin
            mdl_v[wl] = 1'b1;
            mdl_s[wl] = (t > m) ? t - m : 0;
        end
    endtask

    task automatic do_erase();
        @(negedge clk) erase_i = 1'b1;
        @(negedge clk) erase_i = 1'b0;
        for (int i = 0; i < WL_N; i++) mdl_v[i] = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; erase_i = 1'b0; start_i = 1'b0; wl_i = '0; str_i = '0;
        margin_i = '0; max_loops_i = '0;
        vfy_valid_i = 1'b0; vfy_done_i = 1'b0; pass_cnt_i = '0;
        for (int i = 0; i < WL_N; i++) begin mdl_v[i] = 1'b0; mdl_s[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({pulse_o, verify_o, busy_o, done_o, fail_o} == 5'b0, "R1 reset strobes",
            int'({pulse_o, verify_o, busy_o, done_o, fail_o}), 0);
        chk(step_o == '0, "R1 reset step", int'(step_o), 0);

        // Layer 0: learn from string 0, reuse on strings 1..3
        run_op(0, 0, 5, 3, 1, 20, "R3 R4 string0 wl0", 1'b0);
        run_op(0, 1, 5, 3, 1, 20, "R5 string1 wl0", 1'b0);
        run_op(0, 2, 7, 2, 1, 20, "R5 string2 wl0", 1'b0);
        run_op(0, 3, 4, 1, 1, 20, "R5 string3 wl0", 1'b0);
        // Clamp at zero when margin exceeds the first-pass step
        run_op(1, 0, 1, 2, 3, 20, "R4 clamp string0 wl1", 1'b0);
        run_op(1, 1, 1, 2, 3, 20, "R4 clamp reuse wl1", 1'b0);
        // Layer never learned starts at default
        run_op(3, 2, 3, 1, 0, 20, "R3 unlearned wl3", 1'b0);
        // String 1 must not overwrite the layer entry
        run_op(2, 0, 6, 2, 2, 20, "R4 string0 wl2", 1'b0);
        run_op(2, 1, 3, 0, 0, 20, "R6 string1 wl2 single loop", 1'b0);
        run_op(2, 2, 6, 2, 0, 20, "R6 string2 wl2 keeps entry", 1'b0);
        // Loop limit
        run_op(4, 0, 10, 5, 1, 6, "R8 fail wl4", 1'b0);
        repeat (4) @(negedge clk);
        chk(fail_o == 1'b1, "R8 fail held", int'(fail_o), 1);
        chk(pc == 0, "R8 no pulse after fail", pc, 0);
        run_op(4, 1, 2, 1, 1, 20, "R6 no learn after failed string0 wl4", 1'b0);
        // Start while busy
        run_op(5, 0, 4, 3, 1, 20, "R10 start while busy", 1'b1);
        repeat (4) @(negedge clk);
        chk(done_o == 1'b1, "R7 R10 done held", int'(done_o), 1);
        chk(pc == 0, "R10 no extra operation", pc, 0);
        chk(int'(page_o) == 60, "R10 page kept", int'(page_o), 60);
        // Erase clears learned entries
        do_erase();
        run_op(0, 1, 5, 3, 1, 20, "R9 after erase wl0", 1'b0);
        // Page numbering on the last layer
        run_op(7, 3, 2, 1, 0, 20, "R11 page wl7 string3", 1'b0);

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "scoreboard drained", q.size(), 0);
        finish_run();
    end

endmodule